// File: doc/BRIEF.md
# Flash Command Decoder and Erase/Program Sequencer

This block is the command front end of a boot-block NOR flash model. The host presents byte commands one bus write at a time. The block decodes single-cycle mode commands and multi-cycle setup/confirm sequences. It keeps track of which kind of data a read returns: the array, the identifier codes, the query table or the status byte. It also drives an abstract program/erase engine whose run time is counted in clock cycles.

The engine supports suspending an erase, running a complete program while the erase is parked, and resuming the erase afterwards. Resume works no matter which other valid commands the host issues between the nested program and the resume. A lock setup followed by its D0h confirm is taken as a lock operation and does not resume the erase. The D0h that comes after that pair does resume it. The array contents, the lock bits, and all analog and supply behaviour stay outside the block. In array mode `rd_data` reads 00h and the host takes array data from elsewhere.

The write port is a plain strobe with no back-pressure. Every cycle with `wr_valid` high is taken in that cycle, so there is no ready signal. The engine-side outputs are plain status pins.

Top module: `fcui_top`

## Requirements
- R1: A first-cycle write of FFh, 90h, 98h or 70h sets `rd_mode` to 0 (array), 1 (identifier), 2 (query) or 3 (status), whatever `wr_addr` holds.
- R2: Status reads return bit 7 = ready (not busy), bit 6 = erase suspended, bit 5 = erase/sequence error, bit 4 = program/sequence error, and bits 3..0 = 0. A first-cycle 50h clears bits 5 and 4 by the next cycle.
- R3: A 40h or 10h setup, accepted only when the engine is not busy, followed by any data write starts a program. `op_start` pulses for one cycle after the data write, with `op_erase`=0 and the data write's address and byte on `op_addr`/`op_data`. The program stays busy for PROG_CYCLES cycles, and then `op_done` pulses once.
- R4: A 20h setup, accepted only when the engine is neither busy nor suspended, followed by D0h starts an erase. `op_start` pulses with `op_erase`=1 and the confirm address. The erase runs ERASE_CYCLES unsuspended cycles before `op_done`.
- R5: After 20h, a second byte other than D0h sets status bits 5 and 4 and starts nothing. After 60h, a second byte other than 01h, D0h or 2Fh does the same.
- R6: A first-cycle B0h during a running erase freezes it. `op_suspended` and status bit 6 go to 1, status bit 7 goes to 1, and the remaining count holds. B0h has no effect when no erase is running.
- R7: A complete program sequence may run while an erase is suspended. The erase stays suspended through it.
- R8: A first-cycle D0h while an erase is suspended and no program is running resumes the erase. It finishes after its remaining cycles, regardless of FFh, 50h, 70h, 90h, 98h, 60h/D0h or B0h writes issued in between.
- R9: A started program or erase forces `rd_mode` to status, where it stays until a mode command is written.
- R10: In query mode, offsets 10h/11h/12h return 51h/52h/59h, offset 3Ah returns 66h, offsets 3Bh..3Dh return 00h, and every other offset returns 00h.
- R11: In identifier mode, offset 0 returns MFR_CODE, offset 1 returns DEV_CODE, and every other offset returns 00h.
- R12: A low `rst_n` aborts any operation. Afterwards `rd_mode` is array, status reads 80h, and `op_suspended`, `op_start` and `op_done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Bus write strobe, taken in the cycle it is high |
| wr_addr | input | AW | Bus write address |
| wr_data | input | 8 | Bus write command/data byte |
| rd_addr | input | AW | Read offset for identifier/query reads |
| rd_mode | output | 2 | Current read mode (0 array, 1 id, 2 query, 3 status) |
| rd_data | output | 8 | Read byte for the current mode |
| op_start | output | 1 | One-cycle pulse when the engine begins an operation |
| op_erase | output | 1 | Kind of the last started operation (1 erase) |
| op_addr | output | AW | Address of the last started operation |
| op_data | output | 8 | Byte of the last started operation |
| op_suspended | output | 1 | Erase currently suspended |
| op_done | output | 1 | One-cycle pulse when an operation completes |

## Verification
The assertions assume that D0h confirms, B0h suspends and 50h clears are presented only as first-cycle writes when their effect is checked, and that reset is the only thing that can end an operation early. The assertions also assume that no erase is started while one is suspended, a rule the decoder enforces. The stimulus keeps at least one idle cycle between writes and changes `rd_addr` only on the falling edge. It also issues B0h and D0h both where they take effect and where they must be ignored, so the reference model is exercised on both sides of each condition.

// File: rtl/fcui_pkg.sv
`timescale 1ns/1ps
package fcui_pkg;
  typedef enum logic [1:0] {
    MODE_ARRAY  = 2'd0,
    MODE_IDENT  = 2'd1,
    MODE_QUERY  = 2'd2,
    MODE_STATUS = 2'd3
  } rmode_e;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_PROG  = 2'd1,
    SQ_ERASE = 2'd2,
    SQ_LOCK  = 2'd3
  } seq_e;

  localparam logic [7:0] C_ARRAY   = 8'hFF;
  localparam logic [7:0] C_IDENT   = 8'h90;
  localparam logic [7:0] C_QUERY   = 8'h98;
  localparam logic [7:0] C_STATUS  = 8'h70;
  localparam logic [7:0] C_CLEAR   = 8'h50;
  localparam logic [7:0] C_PROG_A  = 8'h40;
  localparam logic [7:0] C_PROG_B  = 8'h10;
  localparam logic [7:0] C_ERASE   = 8'h20;
  localparam logic [7:0] C_CONFIRM = 8'hD0;
  localparam logic [7:0] C_SUSPEND = 8'hB0;
  localparam logic [7:0] C_LOCK    = 8'h60;
  localparam logic [7:0] C_LK_SET  = 8'h01;
  localparam logic [7:0] C_LK_DOWN = 8'h2F;
endpackage

// File: rtl/fcui_decode.sv
`timescale 1ns/1ps
module fcui_decode
  import fcui_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_valid,
  input  logic [7:0] wr_data,
  input  logic       eng_busy,
  input  logic       eng_susp,
  output rmode_e     mode,
  output logic       seq_idle,
  output logic       err_erase,
  output logic       err_prog,
  output logic       start_prog,
  output logic       start_erase,
  output logic       suspend_req,
  output logic       resume_req
);
  seq_e seq_q;
  logic first;

  assign first       = wr_valid && (seq_q == SQ_IDLE);
  assign seq_idle    = (seq_q == SQ_IDLE);
  assign start_prog  = wr_valid && (seq_q == SQ_PROG);
  assign start_erase = wr_valid && (seq_q == SQ_ERASE) && (wr_data == C_CONFIRM);
  assign suspend_req = first && (wr_data == C_SUSPEND);
  assign resume_req  = first && (wr_data == C_CONFIRM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_q     <= SQ_IDLE;
      mode      <= MODE_ARRAY;
      err_erase <= 1'b0;
      err_prog  <= 1'b0;
    end else if (wr_valid) begin
      unique case (seq_q)
        SQ_IDLE: begin
          case (wr_data)
            C_ARRAY:  mode <= MODE_ARRAY;
            C_IDENT:  mode <= MODE_IDENT;
            C_QUERY:  mode <= MODE_QUERY;
            C_STATUS: mode <= MODE_STATUS;
            C_CLEAR: begin
              err_erase <= 1'b0;
              err_prog  <= 1'b0;
            end
            C_PROG_A, C_PROG_B: if (!eng_busy) seq_q <= SQ_PROG;
            C_ERASE:  if (!eng_busy && !eng_susp) seq_q <= SQ_ERASE;
            C_LOCK:   seq_q <= SQ_LOCK;
            default:  ;
          endcase
        end
        SQ_PROG: begin
          seq_q <= SQ_IDLE;
          mode  <= MODE_STATUS;
        end
        SQ_ERASE: begin
          seq_q <= SQ_IDLE;
          mode  <= MODE_STATUS;
          if (wr_data != C_CONFIRM) begin
            err_erase <= 1'b1;
            err_prog  <= 1'b1;
          end
        end
        SQ_LOCK: begin
          seq_q <= SQ_IDLE;
          if (!(wr_data inside {C_LK_SET, C_CONFIRM, C_LK_DOWN})) begin
            err_erase <= 1'b1;
            err_prog  <= 1'b1;
            mode      <= MODE_STATUS;
          end
        end
        default: seq_q <= SQ_IDLE;
      endcase
    end
  end

  // R2: a first-cycle clear leaves both error bits low on the next cycle
  assert_clear_errors_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (first && wr_data == C_CLEAR) |=> (!err_erase && !err_prog));

  // R5: a wrong erase confirm raises both error bits
  assert_bad_confirm_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && seq_q == SQ_ERASE && wr_data != C_CONFIRM) |=> (err_erase && err_prog));
endmodule

// File: rtl/fcui_engine.sv
`timescale 1ns/1ps
module fcui_engine #(
  parameter int AW           = 20,
  parameter int PROG_CYCLES  = 8,
  parameter int ERASE_CYCLES = 40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_prog,
  input  logic          start_erase,
  input  logic          suspend_req,
  input  logic          resume_req,
  input  logic [AW-1:0] in_addr,
  input  logic [7:0]    in_data,
  output logic          busy,
  output logic          e_susp,
  output logic          p_active,
  output logic          op_start,
  output logic          op_erase,
  output logic [AW-1:0] op_addr,
  output logic [7:0]    op_data,
  output logic          op_done
);
  localparam int MAXC = (ERASE_CYCLES > PROG_CYCLES) ? ERASE_CYCLES : PROG_CYCLES;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] P_LOAD = CW'(PROG_CYCLES);
  localparam logic [CW-1:0] E_LOAD = CW'(ERASE_CYCLES);
  localparam logic [CW-1:0] ONE    = CW'(1);

  logic [CW-1:0] p_cnt, e_cnt;
  logic          e_active;
  logic          sus_eff, res_eff, p_fin, e_fin, e_run;

  assign e_run   = e_active && !e_susp;
  assign busy    = p_active || e_run;
  assign sus_eff = suspend_req && e_run;
  assign res_eff = resume_req && e_susp && !p_active;
  assign p_fin   = !start_prog && p_active && (p_cnt == ONE);
  assign e_fin   = !start_erase && e_run && !sus_eff && (e_cnt == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_active <= 1'b0;
      p_cnt    <= '0;
    end else if (start_prog) begin
      p_active <= 1'b1;
      p_cnt    <= P_LOAD;
    end else if (p_active) begin
      if (p_fin) p_active <= 1'b0;
      else       p_cnt    <= p_cnt - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_active <= 1'b0;
      e_susp   <= 1'b0;
      e_cnt    <= '0;
    end else if (start_erase) begin
      e_active <= 1'b1;
      e_susp   <= 1'b0;
      e_cnt    <= E_LOAD;
    end else if (e_run) begin
      if (sus_eff)    e_susp   <= 1'b1;
      else if (e_fin) e_active <= 1'b0;
      else            e_cnt    <= e_cnt - ONE;
    end else if (res_eff) begin
      e_susp <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_start <= 1'b0;
      op_done  <= 1'b0;
      op_erase <= 1'b0;
      op_addr  <= '0;
      op_data  <= '0;
    end else begin
      op_start <= start_prog || start_erase;
      op_done  <= p_fin || e_fin;
      if (start_prog || start_erase) begin
        op_erase <= start_erase;
        op_addr  <= in_addr;
        op_data  <= in_data;
      end
    end
  end

  // R6: a parked erase keeps its remaining count until resumed
  assert_susp_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (e_susp && !res_eff && !start_erase) |=> $stable(e_cnt));

  // R7: the program and an unsuspended erase never run together
  assert_single_op_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(p_active && e_run));

  // R3: completion is reported only once the engine has gone idle
  assert_done_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    op_done |-> !busy);
endmodule

// File: rtl/fcui_readout.sv
`timescale 1ns/1ps
module fcui_readout
  import fcui_pkg::*;
#(
  parameter int         AW       = 20,
  parameter logic [7:0] MFR_CODE = 8'hA7,
  parameter logic [7:0] DEV_CODE = 8'h5C
) (
  input  rmode_e        mode,
  input  logic [AW-1:0] rd_addr,
  input  logic          busy,
  input  logic          e_susp,
  input  logic          err_erase,
  input  logic          err_prog,
  output logic [7:0]    rd_data
);
  function automatic logic [7:0] query_byte(input logic [AW-1:0] a);
    logic [7:0] v;
    v = 8'h00;
    if (a == AW'(8'h10)) v = 8'h51;
    if (a == AW'(8'h11)) v = 8'h52;
    if (a == AW'(8'h12)) v = 8'h59;
    if (a == AW'(8'h3A)) v = 8'h66;
    return v;
  endfunction

  always_comb begin
    unique case (mode)
      MODE_IDENT:  rd_data = (rd_addr == AW'(0)) ? MFR_CODE :
                             (rd_addr == AW'(1)) ? DEV_CODE : 8'h00;
      MODE_QUERY:  rd_data = query_byte(rd_addr);
      MODE_STATUS: rd_data = {!busy, e_susp, err_erase, err_prog, 4'b0000};
      default:     rd_data = 8'h00;
    endcase
  end
endmodule

// File: rtl/fcui_top.sv
`timescale 1ns/1ps
module fcui_top
  import fcui_pkg::*;
#(
  parameter int         AW           = 20,
  parameter int         PROG_CYCLES  = 8,
  parameter int         ERASE_CYCLES = 40,
  parameter logic [7:0] MFR_CODE     = 8'hA7,
  parameter logic [7:0] DEV_CODE     = 8'h5C
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [1:0]    rd_mode,
  output logic [7:0]    rd_data,
  output logic          op_start,
  output logic          op_erase,
  output logic [AW-1:0] op_addr,
  output logic [7:0]    op_data,
  output logic          op_suspended,
  output logic          op_done
);
  rmode_e mode;
  logic seq_idle, err_erase, err_prog;
  logic start_prog, start_erase, suspend_req, resume_req;
  logic busy, e_susp, p_active;

  fcui_decode u_dec (
    .clk, .rst_n, .wr_valid, .wr_data,
    .eng_busy(busy), .eng_susp(e_susp),
    .mode, .seq_idle, .err_erase, .err_prog,
    .start_prog, .start_erase, .suspend_req, .resume_req
  );

  fcui_engine #(.AW(AW), .PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)) u_eng (
    .clk, .rst_n, .start_prog, .start_erase, .suspend_req, .resume_req,
    .in_addr(wr_addr), .in_data(wr_data),
    .busy, .e_susp, .p_active,
    .op_start, .op_erase, .op_addr, .op_data, .op_done
  );

  fcui_readout #(.AW(AW), .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)) u_rd (
    .mode, .rd_addr, .busy, .e_susp, .err_erase, .err_prog, .rd_data
  );

  assign rd_mode      = mode;
  assign op_suspended = e_susp;

  // R9: reads show status in the cycle an operation is reported started
  assert_start_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |-> (mode == MODE_STATUS));

  // R8: a first-cycle confirm resumes a parked erase when no program runs
  assert_resume_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && seq_idle && wr_data == C_CONFIRM && e_susp && !p_active) |=> !e_susp);
endmodule

// File: tb/fcui_top_tb_top.sv
`timescale 1ns/1ps
module fcui_top_tb_top;
  localparam int AW = 20;
  localparam int PC = 8;
  localparam int EC = 40;
  localparam logic [7:0] MFR = 8'hA7;
  localparam logic [7:0] DEV = 8'h5C;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [1:0] rd_mode;
  logic [7:0] rd_data;
  logic op_start, op_erase, op_suspended, op_done;
  logic [AW-1:0] op_addr;
  logic [7:0] op_data;

  always #2.5 clk = ~clk;

  fcui_top #(.AW(AW), .PROG_CYCLES(PC), .ERASE_CYCLES(EC), .MFR_CODE(MFR), .DEV_CODE(DEV)) dut_i (
    .clk, .rst_n, .wr_valid, .wr_addr, .wr_data, .rd_addr,
    .rd_mode, .rd_data, .op_start, .op_erase, .op_addr, .op_data,
    .op_suspended, .op_done
  );

  // reference model state
  int m_mode, m_seq, p_cnt, e_cnt;
  bit m_errE, m_errP, p_act, e_act, e_susp, m_start, m_done, m_kind;
  logic [AW-1:0] m_addr;
  logic [7:0] m_data;
  int vecs = 0, fails = 0;
  string cur_req = "R12";
  bit finished = 0;

  task automatic model_reset();
    m_mode = 0; m_seq = 0; p_cnt = 0; e_cnt = 0;
    m_errE = 0; m_errP = 0; p_act = 0; e_act = 0; e_susp = 0;
    m_start = 0; m_done = 0; m_kind = 0; m_addr = '0; m_data = '0;
  endtask

  task automatic model_step();
    bit es0, busy, sp, se, sus, res, pf, ef;
    es0  = e_susp;
    busy = p_act || (e_act && !e_susp);
    sp   = wr_valid && m_seq == 1;
    se   = wr_valid && m_seq == 2 && wr_data == 8'hD0;
    sus  = wr_valid && m_seq == 0 && wr_data == 8'hB0 && e_act && !e_susp;
    res  = wr_valid && m_seq == 0 && wr_data == 8'hD0 && e_susp && !p_act;
    pf = 0; ef = 0;
    if (sp) begin p_act = 1; p_cnt = PC; end
    else if (p_act) begin if (p_cnt == 1) begin p_act = 0; pf = 1; end else p_cnt--; end
    if (se) begin e_act = 1; e_cnt = EC; e_susp = 0; end
    else if (e_act && !e_susp) begin
      if (sus) e_susp = 1;
      else if (e_cnt == 1) begin e_act = 0; ef = 1; end
      else e_cnt--;
    end else if (res) e_susp = 0;
    m_start = sp || se;
    if (sp || se) begin m_kind = se; m_addr = wr_addr; m_data = wr_data; end
    m_done = pf || ef;
    if (wr_valid) begin
      case (m_seq)
        0: case (wr_data)
             8'hFF: m_mode = 0;
             8'h90: m_mode = 1;
             8'h98: m_mode = 2;
             8'h70: m_mode = 3;
             8'h50: begin m_errE = 0; m_errP = 0; end
             8'h40, 8'h10: if (!busy) m_seq = 1;
             8'h20: if (!busy && !es0) m_seq = 2;
             8'h60: m_seq = 3;
             default: ;
           endcase
        1: begin m_seq = 0; m_mode = 3; end
        2: begin m_seq = 0; m_mode = 3;
                 if (wr_data != 8'hD0) begin m_errE = 1; m_errP = 1; end end
        default: begin
          m_seq = 0;
          if (wr_data != 8'h01 && wr_data != 8'hD0 && wr_data != 8'h2F) begin
            m_errE = 1; m_errP = 1; m_mode = 3;
          end
        end
      endcase
    end
  endtask

  function automatic logic [7:0] exp_rd();
    logic [7:0] v;
    v = 8'h00;
    case (m_mode)
      1: v = (rd_addr == 0) ? MFR : (rd_addr == 1) ? DEV : 8'h00;
      2: begin
        if (rd_addr == 'h10) v = 8'h51;
        if (rd_addr == 'h11) v = 8'h52;
        if (rd_addr == 'h12) v = 8'h59;
        if (rd_addr == 'h3A) v = 8'h66;
      end
      3: v = {!(p_act || (e_act && !e_susp)), e_susp, m_errE, m_errP, 4'b0};
      default: v = 8'h00;
    endcase
    return v;
  endfunction

  task automatic cmp(input string f, input logic [31:0] act, input logic [31:0] exp);
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h at %0t", cur_req, f, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) model_reset(); else model_step();
    #1;
    if (!finished) begin
      vecs++;
      cmp("rd_mode", 32'(rd_mode), 32'(m_mode));
      cmp("rd_data", 32'(rd_data), 32'(exp_rd()));
      cmp("op_start", 32'(op_start), 32'(m_start));
      cmp("op_done", 32'(op_done), 32'(m_done));
      cmp("op_suspended", 32'(op_suspended), 32'(e_susp));
      cmp("op_erase", 32'(op_erase), 32'(m_kind));
      cmp("op_addr", 32'(op_addr), 32'(m_addr));
      cmp("op_data", 32'(op_data), 32'(m_data));
    end
  end

  task automatic wr(input logic [7:0] d, input logic [AW-1:0] a);
    @(negedge clk);
    wr_valid = 1'b1; wr_data = d; wr_addr = a;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // constant-expectation check, called just after a falling edge
  task automatic expk(input logic [AW-1:0] a, input logic [7:0] e, input string req);
    rd_addr = a;
    #0.5;
    vecs++;
    if (rd_data !== e) begin
      fails++;
      $display("FAIL %s rd_data@%h: actual %h expected %h", req, a, rd_data, e);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    cur_req = "R12"; wr(8'h70, 0); expk(0, 8'h80, "R12");
    cur_req = "R1"; wr(8'hFF, 'h3A); idle(1); expk(0, 8'h00, "R1");
    cur_req = "R11"; wr(8'h90, 'h777);
    expk(0, MFR, "R11"); expk(1, DEV, "R11"); expk(2, 8'h00, "R11");
    cur_req = "R10"; wr(8'h98, 'h5);
    expk('h10, 8'h51, "R10"); expk('h11, 8'h52, "R10"); expk('h12, 8'h59, "R10");
    expk('h3A, 8'h66, "R10"); expk('h3B, 8'h00, "R10"); expk('h3C, 8'h00, "R10");
    expk('h3D, 8'h00, "R10"); expk('h3E, 8'h00, "R10");
    cur_req = "R1"; wr(8'h70, 'h3A); idle(2);
    // program, both setup codes
    cur_req = "R3"; rd_addr = 0;
    wr(8'h40, 0); wr(8'hAA, 'h123); idle(PC + 3);
    wr(8'hFF, 0);
    wr(8'h10, 0); wr(8'h3C, 'h9A); idle(PC + 3);
    cur_req = "R9"; wr(8'h90, 0); idle(2);
    // erase
    cur_req = "R4"; wr(8'h20, 0); wr(8'hD0, 'h4000);
    wr(8'h40, 0); idle(EC + 3); // setup while busy is ignored
    // bad confirms
    cur_req = "R5"; wr(8'hFF, 0); wr(8'h20, 0); wr(8'h33, 'h4000); idle(2);
    cur_req = "R2"; wr(8'h50, 0); idle(2);
    cur_req = "R5"; wr(8'hFF, 0); wr(8'h60, 0); wr(8'h77, 0); idle(2);
    cur_req = "R2"; wr(8'h50, 0); wr(8'h60, 0); wr(8'h01, 'h8000); idle(2);
    // suspend with nothing running
    cur_req = "R6"; wr(8'h70, 0); wr(8'hB0, 0); idle(3);
    // suspend / nested program / noise / resume
    wr(8'h20, 0); wr(8'hD0, 'h2000); idle(5);
    wr(8'hB0, 0); idle(10);
    cur_req = "R7"; wr(8'h40, 0); wr(8'h55, 'h10);
    wr(8'hD0, 0); // resume refused while the program runs
    idle(PC + 2);
    cur_req = "R8";
    wr(8'hFF, 0); wr(8'h50, 0); wr(8'h70, 0); wr(8'h90, 0); wr(8'h98, 0);
    wr(8'h60, 0); wr(8'hD0, 'h2000); wr(8'hB0, 0); wr(8'h70, 0);
    wr(8'hD0, 0); idle(8);
    wr(8'hB0, 0); idle(4); wr(8'hD0, 0); idle(EC);
    // reset mid-erase
    cur_req = "R12"; wr(8'h20, 0); wr(8'hD0, 'h1000); idle(4); wr(8'hB0, 0);
    @(negedge clk); rst_n = 1'b0; idle(2); rst_n = 1'b1; idle(2);
    wr(8'h70, 0); expk(0, 8'h80, "R12"); idle(2);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule